// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width-modulated outputs. A small register bus writes and reads them. Each channel owns one 32-bit control word. The word carries an enable flag, an 8-bit high-time count and a 13-bit clock divider. The divider slows the input clock by its value plus one to make a tick. Every period is exactly 256 ticks long. The output is high for the first `duty` ticks of each period and low for the rest.

Each channel runs a two-state machine. In `CH_OFF` the output is low and both the tick and divider counters sit at zero. The transition `start` (OFF to RUN) happens on the first clock on which the enable flag is seen set. It copies the duty and divider values into working copies and begins a fresh period. In `CH_RUN` the counters advance. The transition `wrap` (RUN to RUN) fires on the last clock of a period: the tick counter returns to zero and the working copies are reloaded from the control word, so changes made while running only apply from the following period. The transition `stop` (RUN to OFF) happens on the first clock on which the enable flag is seen clear.

Software places channel `k` at byte address `k*16`. Reads are registered: data appears on the clock after the read strobe and holds until the next read.

Top module: `pwm_quad_top`

## Requirements
- R1: Channel k's control word sits at byte address k*16 (address bits 5:4 pick the channel, bits 3:0 must be zero). A write to any other address changes nothing. A read of any other address returns zero. Read data appears one clock after `bus_rd_en` is sampled high.
- R2: Control word layout: bit 31 is enable, bits 23:16 are duty, bits 12:0 are the divider. Every other bit reads back as zero, and writes to those bits are ignored.
- R3: One tick lasts divider+1 input clocks, so a period lasts 256*(divider+1) clocks.
- R4: While running, the output is high for the first `duty` ticks of each period and low for the remaining ticks. Duty 0 keeps the output low. Duty 255 gives 255 high ticks and one low tick per period.
- R5: When a write clears the enable bit (including a write of all zeros), the output is low from the clock after the write and stays low.
- R6: A write that keeps the enable bit set does not interrupt the channel. The new duty and divider take effect only from the next period boundary, and the current period completes with the old values.
- R7: While disabled, the counters are held at zero. A write that sets enable on a disabled channel starts a fresh period on the next clock, with the output high in that first clock when duty is nonzero.
- R8: Channels are independent: writing one channel does not disturb the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and all channels |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the control word |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
Suppose a working copy of duty or divider is reloaded at the wrong moment. Then a live update reshapes the period that is already running. The bench sees this as an output level mismatch within a few clocks of the write, rather than only after the boundary. If the tick or divider counter is not cleared on disable, a re-enabled channel does not start high on the first clock after its write, and the error shows one clock after the enable. A stuck state machine or a wrong divider compare moves the falling edge or the next period's rising edge. The bench checks both edges at the exact clock where they are due.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    localparam int REG_W     = 32;
    localparam int DUTY_W    = 8;
    localparam int PRESC_W   = 13;
    localparam int EN_BIT    = 31;
    localparam int DUTY_LSB  = 16;
    localparam int PRESC_LSB = 0;

    localparam logic [REG_W-1:0] USED_MASK =
        (REG_W'(1) << EN_BIT) |
        (((REG_W'(1) << DUTY_W) - REG_W'(1)) << DUTY_LSB) |
        (((REG_W'(1) << PRESC_W) - REG_W'(1)) << PRESC_LSB);

    typedef struct packed {
        logic               en;
        logic [DUTY_W-1:0]  duty;
        logic [PRESC_W-1:0] presc;
    } chan_cfg_t;

    typedef enum logic [0:0] {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } chan_state_t;

    function automatic logic [REG_W-1:0] cfg_to_word(chan_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]                 = c.en;
        w[DUTY_LSB +: DUTY_W]     = c.duty;
        w[PRESC_LSB +: PRESC_W]   = c.presc;
        return w;
    endfunction

    function automatic chan_cfg_t word_to_cfg(logic [REG_W-1:0] w);
        chan_cfg_t c;
        c.en    = w[EN_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.presc = w[PRESC_LSB +: PRESC_W];
        return c;
    endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int ADDR_W       = 6,
    parameter int STRIDE_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_en_i,
    input  logic [REG_W-1:0]         wdata_i,
    input  logic                     rd_en_i,
    output logic [REG_W-1:0]         rdata_o,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [REG_W-1:0] rd_word;

    // decode: exact word offset inside the stride, channel index in range
    always_comb begin
        sel = SEL_W'(addr_i >> STRIDE_SHIFT);
        hit = (addr_i[STRIDE_SHIFT-1:0] == '0) &&
              (int'(addr_i >> STRIDE_SHIFT) < NUM_CH);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[g] <= '0;
            end else if (wr_en_i && hit && (sel == SEL_W'(g))) begin
                cfg_o[g] <= word_to_cfg(wdata_i);
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit && (sel == SEL_W'(i))) begin
                rd_word = cfg_to_word(cfg_o[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_word;
        end
    end

    // R2: undefined bit positions never appear on the read port
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~USED_MASK) == '0);

    // R1: a read of an unmapped address returns zero on the next clock
    assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> (rdata_o == '0));

endmodule

// File: rtl/pwm_quad_prescaler.sv
module pwm_quad_prescaler #(
    parameter int PRESC_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PRESC_W-1:0] limit_i,
    output logic               strobe_o
);

    logic [PRESC_W-1:0] cnt;

    assign strobe_o = run_i && (cnt == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i || strobe_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the divider never runs past its limit while active
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt <= limit_i));

    // R7: an idle divider is parked at zero
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt == '0));

endmodule

// File: rtl/pwm_quad_channel.sv
module pwm_quad_channel
    import pwm_quad_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    localparam logic [DUTY_W-1:0] TICK_LAST = '1;

    chan_state_t        state, state_nxt;
    logic [DUTY_W-1:0]  tick;
    logic [DUTY_W-1:0]  duty_act;
    logic [PRESC_W-1:0] presc_act;
    logic               run;
    logic               strobe;
    logic               wrap;

    assign run  = (state == CH_RUN);
    assign wrap = strobe && (tick == TICK_LAST);

    pwm_quad_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .limit_i  (presc_act),
        .strobe_o (strobe)
    );

    // next state: start / stop follow the enable flag, wrap stays in RUN
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_OFF: state_nxt = cfg_i.en ? CH_RUN : CH_OFF;
            CH_RUN: state_nxt = cfg_i.en ? CH_RUN : CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // tick counter and working copies, reloaded on start and on wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick      <= '0;
            duty_act  <= '0;
            presc_act <= '0;
        end else if (!run || !cfg_i.en) begin
            tick <= '0;
            if (!run && cfg_i.en) begin
                duty_act  <= cfg_i.duty;
                presc_act <= cfg_i.presc;
            end
        end else if (strobe) begin
            tick <= tick + 1'b1;
            if (wrap) begin
                duty_act  <= cfg_i.duty;
                presc_act <= cfg_i.presc;
            end
        end
    end

    // output process
    always_comb begin
        pwm_o = run && (tick < duty_act);
    end

    // R5: a cleared enable forces the output low from the following clock
    assert_disable_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> !pwm_o);

    // R7: a channel sitting in OFF has its tick counter at zero
    assert_off_counters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OFF) |-> (tick == '0));

    // R3: the tick counter only moves on a divider strobe
    assert_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg_i.en && !strobe) |=> $stable(tick));

    // R6: working copies are frozen inside a running period
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(duty_act) && $stable(presc_act)));

endmodule

// File: rtl/pwm_quad_top.sv
module pwm_quad_top
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int STRIDE_SHIFT = 4,
    parameter int ADDR_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0] cfg;

    pwm_quad_regs #(
        .NUM_CH       (NUM_CH),
        .ADDR_W       (ADDR_W),
        .STRIDE_SHIFT (STRIDE_SHIFT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_en_i (bus_wr_en),
        .wdata_i (bus_wdata),
        .rd_en_i (bus_rd_en),
        .rdata_o (bus_rdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_quad_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm_quad_top_tb_top.sv
module pwm_quad_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        int    ch;
        logic  lvl;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    pwm_quad_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rd_en (bus_rd_en),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // monitor: pops scheduled expectations and compares the output levels
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            check((e.at == cyc) && (pwm_out[e.ch] === e.lvl),
                  $sformatf("%s ch%0d at %0d", e.tag, e.ch, e.at),
                  {31'd0, pwm_out[e.ch]}, {31'd0, e.lvl});
        end
    end

    task automatic expect_lvl(input int at, input int ch, input logic lvl, input string tag);
        exp_t e;
        e.at = at; e.ch = ch; e.lvl = lvl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
        e = cyc;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int e, s;
        logic [31:0] d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R1, R5)
        check(pwm_out == 4'b0, "R5 reset outputs low", {28'd0, pwm_out}, 32'd0);
        rd(6'h00, d);
        check(d == 32'd0, "R1 reset readback ch0", d, 32'd0);

        // field layout and reserved bits (R2), unmapped read (R1)
        wr(6'h10, 32'hFFFF_FFFF, e);
        rd(6'h10, d);
        check(d == 32'h80FF_1FFF, "R2 readback mask ch1", d, 32'h80FF_1FFF);
        rd(6'h14, d);
        check(d == 32'd0, "R1 unmapped offset reads zero", d, 32'd0);
        wr(6'h10, 32'd0, e);
        rd(6'h10, d);
        check(d == 32'd0, "R5 zero write clears ch1", d, 32'd0);
        expect_lvl(cyc + 1, 1, 1'b0, "R5 ch1 low after zero write");
        drain();

        // duty 3, divider 0 (R4, R3, R7)
        wr(6'h00, 32'h8003_0000, e);
        s = e + 1;
        expect_lvl(s,       0, 1'b1, "R7 fresh period starts high");
        expect_lvl(s + 2,   0, 1'b1, "R4 last high tick");
        expect_lvl(s + 3,   0, 1'b0, "R4 first low tick");
        expect_lvl(s + 255, 0, 1'b0, "R4 final tick low");
        expect_lvl(s + 256, 0, 1'b1, "R3 period of 256 clocks");
        expect_lvl(s + 258, 0, 1'b1, "R4 second period high");
        expect_lvl(s + 259, 0, 1'b0, "R4 second period low");
        drain();

        // stop, then fresh restart with duty 200 and a live update to duty 5 (R5, R7, R6)
        wr(6'h00, 32'd0, e);
        expect_lvl(e + 1, 0, 1'b0, "R5 stopped by zero write");
        drain();
        wr(6'h00, 32'h80C8_0000, e);
        s = e + 1;
        expect_lvl(s, 0, 1'b1, "R7 restart high on first clock");
        drain();
        repeat (20) @(negedge clk);
        wr(6'h00, 32'h8005_0000, e);
        expect_lvl(s + 100, 0, 1'b1, "R6 current period keeps old duty");
        expect_lvl(s + 199, 0, 1'b1, "R6 old duty last high");
        expect_lvl(s + 200, 0, 1'b0, "R6 old duty falls");
        expect_lvl(s + 256, 0, 1'b1, "R6 channel kept running");
        expect_lvl(s + 260, 0, 1'b1, "R6 new duty high");
        expect_lvl(s + 261, 0, 1'b0, "R6 new duty falls");
        drain();

        // clear enable while output is high (R5)
        while (cyc < s + 512) @(negedge clk);
        wr(6'h00, 32'h0005_0000, e);
        expect_lvl(e + 1, 0, 1'b0, "R5 low after enable cleared");
        expect_lvl(e + 2, 0, 1'b0, "R5 stays low");
        drain();
        rd(6'h00, d);
        check(d == 32'h0005_0000, "R2 duty kept with enable clear", d, 32'h0005_0000);

        // duty 0 and duty 255 (R4)
        wr(6'h20, 32'h8000_0000, e);
        s = e + 1;
        expect_lvl(s,       2, 1'b0, "R4 duty zero low");
        expect_lvl(s + 128, 2, 1'b0, "R4 duty zero mid");
        expect_lvl(s + 256, 2, 1'b0, "R4 duty zero next period");
        drain();
        wr(6'h20, 32'd0, e);
        wr(6'h20, 32'h80FF_0000, e);
        s = e + 1;
        expect_lvl(s,       2, 1'b1, "R4 duty 255 high");
        expect_lvl(s + 254, 2, 1'b1, "R4 duty 255 tick 254 high");
        expect_lvl(s + 255, 2, 1'b0, "R4 duty 255 single low tick");
        expect_lvl(s + 256, 2, 1'b1, "R4 duty 255 wraps high");
        drain();

        // divider 1, duty 2 (R3)
        wr(6'h30, 32'h8002_0001, e);
        s = e + 1;
        expect_lvl(s + 3,   3, 1'b1, "R3 two ticks of two clocks");
        expect_lvl(s + 4,   3, 1'b0, "R3 falls after four clocks");
        expect_lvl(s + 511, 3, 1'b0, "R3 low to period end");
        expect_lvl(s + 512, 3, 1'b1, "R3 period of 512 clocks");
        drain();

        // independence (R8): stop ch2 while ch3 runs
        wr(6'h20, 32'd0, e);
        expect_lvl(e + 1,    2, 1'b0, "R8 ch2 stopped");
        expect_lvl(s + 1024, 3, 1'b1, "R8 ch3 undisturbed high");
        expect_lvl(s + 1027, 3, 1'b1, "R8 ch3 undisturbed last high");
        expect_lvl(s + 1028, 3, 1'b0, "R8 ch3 undisturbed low");
        drain();

        // write to a non-word offset is ignored (R1)
        wr(6'h04, 32'hFFFF_FFFF, e);
        expect_lvl(e + 1,  0, 1'b0, "R1 ignored write leaves ch0 off");
        expect_lvl(e + 10, 0, 1'b0, "R1 ignored write ch0 still off");
        drain();
        rd(6'h00, d);
        check(d == 32'h0005_0000, "R1 ignored write ch0 unchanged", d, 32'h0005_0000);
        rd(6'h04, d);
        check(d == 32'd0, "R1 offset 4 reads zero", d, 32'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule